// File: doc/BRIEF.md
# Address Translation Unit with Hardware Table Walk

This block turns 32-bit virtual addresses from one requester into physical addresses. It keeps recent page mappings in a small fully associative lookup buffer. A request that finds its page there is answered on the next clock edge. A request that misses starts an in-hardware walk of a single-level page table. The walker forms the entry address from a base register plus the virtual page number scaled by the entry size, and fetches that entry over a simple read port. The base register holds a physical address, so this fetch is not translated.

If the fetched entry is marked valid, its mapping is installed in the buffer and the request is looked up again. If the entry is marked invalid, the request completes with a fault indication. A sticky fault flag is set and the faulting virtual address is held for software. Once software has filled in the entry and clears the flag, the requester issues the same address again; it walks again and completes normally. A flush input empties the buffer. Writing the base register also empties it.

Top module: `xlat_mmu`

## Requirements
- R1: A request accepted (req_valid and req_ready high at a rising edge) whose page is held in the buffer produces rsp_valid=1 with rsp_fault=0 in the very next cycle, and issues no memory read.
- R2: The response address is the cached physical page number in bits 31:12, with bits 11:0 copied unchanged from the virtual address (4 KiB pages).
- R3: On a miss, exactly one memory read is issued, at address pt_base + 4 × VPN, where VPN is the virtual address bits 31:12. In a fetched entry, bit 0 is the valid flag and bits 31:12 hold the physical page number.
- R4: A fetched entry with bit 0 set is installed, and the request then completes with the translated address. Later requests to the same page hit with no further read.
- R5: A fetched entry with bit 0 clear completes the request with rsp_valid=1, rsp_fault=1 and rsp_paddr=0. It also sets fault_flag and loads fault_vaddr with the request's virtual address.
- R6: fault_flag stays set until fault_clear is pulsed, and it drops in the cycle after the pulse. If a new fault and fault_clear fall in the same cycle, the flag stays set and fault_vaddr takes the new address.
- R7: After the entry has been made valid, reissuing the faulting address walks the table again and returns the correct physical address without a fault.
- R8: req_ready is low from the acceptance of a missing request until its response, so only one request is in flight.
- R9: A flush pulse empties all buffer entries in one cycle. If a flush falls in the same cycle as an install, the install is discarded and the retry walks the table a second time.
- R10: Writing pt_base (ptbase_wr=1) empties the buffer, and later walks use the new base.
- R11: The buffer holds 8 entries, replaced in round-robin order. After 9 distinct pages are installed following a flush, the first page misses and the third still hits.
- R12: After reset, req_ready=1, rsp_valid=0, mem_rd_en=0, fault_flag=0 and fault_vaddr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_paddr | output | 32 | Translated physical address |
| mem_rd_en | output | 1 | One-cycle table entry read request |
| mem_rd_addr | output | 32 | Physical address of the entry |
| mem_rd_valid | input | 1 | Entry data returned |
| mem_rd_data | input | 32 | Entry data |
| ptbase_wr | input | 1 | Load the table base register |
| ptbase_wdata | input | 32 | New table base (physical) |
| flush | input | 1 | Empty the lookup buffer |
| fault_clear | input | 1 | Clear the sticky fault flag |
| fault_flag | output | 1 | Sticky fault indication |
| fault_vaddr | output | 32 | Virtual address of the latest fault |

## Verification
Two pairs of events can land on the same edge. The first pair is an install and a flush. The bench raises flush in exactly the cycle in which returned entry data is present. It then expects two table reads for one request, followed by a correct translation. The second pair is a fault and its clear. The bench pulses fault_clear in the cycle in which an invalid entry returns. It then expects the flag to remain set, with the newer faulting address captured.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W     = 32;
    localparam int PA_W     = 32;
    localparam int PG_BITS  = 12;
    localparam int VPN_W    = VA_W - PG_BITS;
    localparam int PPN_W    = PA_W - PG_BITS;
    localparam int PTE_W    = 32;
    localparam int PTE_LG   = 2;
    localparam int TLB_N    = 8;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_READ  = 2'd1,
        W_WAIT  = 2'd2,
        W_RETRY = 2'd3
    } walk_st_t;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             ok;
    } pte_t;

    function automatic pte_t pte_decode(input logic [PTE_W-1:0] raw);
        pte_t p;
        p.ppn = raw[PTE_W-1 -: PPN_W];
        p.ok  = raw[0];
        return p;
    endfunction

    function automatic logic [PA_W-1:0] pte_addr(input logic [PA_W-1:0] base,
                                                 input logic [VPN_W-1:0] vpn);
        return base + (PA_W'(vpn) << PTE_LG);
    endfunction
endpackage

// File: rtl/tlb_victim_rr.sv
module tlb_victim_rr #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    output logic [IW-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (advance)
            idx <= (idx == IW'(N - 1)) ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import xlat_pkg::*;
#(
    parameter int N = TLB_N,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic             flush
);
    logic [N-1:0]     ent_ok;
    logic [VPN_W-1:0] ent_vpn [N];
    logic [PPN_W-1:0] ent_ppn [N];
    logic [N-1:0]     match;
    logic [IW-1:0]    victim;
    logic             do_ins;

    assign do_ins = ins_en && !flush;

    tlb_victim_rr #(.N(N)) u_rr (
        .clk     (clk),
        .rst     (rst),
        .advance (do_ins),
        .idx     (victim)
    );

    for (genvar g = 0; g < N; g++) begin : g_ent
        assign match[g] = ent_ok[g] && (ent_vpn[g] == lk_vpn);

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                ent_ok[g] <= 1'b0;
            end else if (do_ins && victim == IW'(g)) begin
                ent_ok[g]  <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_vpn[g] <= '0;
                ent_ppn[g] <= '0;
            end else if (do_ins && victim == IW'(g)) begin
                ent_vpn[g] <= ins_vpn;
                ent_ppn[g] <= ins_ppn;
            end
        end
    end

    assign lk_hit = |match;

    always_comb begin
        lk_ppn = '0;
        for (int i = 0; i < N; i++)
            if (match[i]) lk_ppn = lk_ppn | ent_ppn[i];
    end

    // R9: after a flush no lookup can hit
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> !lk_hit);

    // R11: one page never sits in two entries
    a_r11_unique_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_hit,
    input  logic [PPN_W-1:0] lk_ppn,
    output logic             ins_en,
    output logic [VPN_W-1:0] ins_vpn,
    output logic [PPN_W-1:0] ins_ppn,
    input  logic [PA_W-1:0]  pt_base,
    output logic             mem_rd_en,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [PTE_W-1:0] mem_rd_data,
    output logic             fault_event,
    output logic [VA_W-1:0]  fault_addr
);
    walk_st_t        st;
    logic [VA_W-1:0] held;
    pte_t            pte;

    assign pte       = pte_decode(mem_rd_data);
    assign req_ready = (st == W_IDLE);
    assign lk_vpn    = (st == W_IDLE) ? req_vaddr[VA_W-1 -: VPN_W]
                                      : held[VA_W-1 -: VPN_W];
    assign mem_rd_en   = (st == W_READ);
    assign mem_rd_addr = pte_addr(pt_base, held[VA_W-1 -: VPN_W]);
    assign ins_en      = (st == W_WAIT) && mem_rd_valid && pte.ok;
    assign ins_vpn     = held[VA_W-1 -: VPN_W];
    assign ins_ppn     = pte.ppn;
    assign fault_event = (st == W_WAIT) && mem_rd_valid && !pte.ok;
    assign fault_addr  = held;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= W_IDLE;
            held      <= '0;
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            unique case (st)
                W_IDLE: if (req_valid) begin
                    held <= req_vaddr;
                    if (lk_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_paddr <= {lk_ppn, req_vaddr[PG_BITS-1:0]};
                    end else begin
                        st <= W_READ;
                    end
                end
                W_READ: st <= W_WAIT;
                W_WAIT: if (mem_rd_valid) begin
                    if (pte.ok) begin
                        st <= W_RETRY;
                    end else begin
                        rsp_valid <= 1'b1;
                        rsp_fault <= 1'b1;
                        rsp_paddr <= '0;
                        st        <= W_IDLE;
                    end
                end
                W_RETRY: begin
                    if (lk_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_paddr <= {lk_ppn, held[PG_BITS-1:0]};
                        st        <= W_IDLE;
                    end else begin
                        st <= W_READ;
                    end
                end
                default: st <= W_IDLE;
            endcase
        end
    end

    // R1: an accepted hit answers on the next cycle without fault
    a_r1_hit_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && lk_hit) |=> (rsp_valid && !rsp_fault));

    // R3: table reads are single-cycle pulses
    a_r3_single_read: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    // R8: an accepted miss closes the request port
    a_r8_busy_on_miss: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !lk_hit) |=> (!req_ready && !rsp_valid));
endmodule

// File: rtl/xlat_mmu.sv
module xlat_mmu
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             mem_rd_en,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [PTE_W-1:0] mem_rd_data,
    input  logic             ptbase_wr,
    input  logic [PA_W-1:0]  ptbase_wdata,
    input  logic             flush,
    input  logic             fault_clear,
    output logic             fault_flag,
    output logic [VA_W-1:0]  fault_vaddr
);
    logic [PA_W-1:0]  pt_base;
    logic [VPN_W-1:0] lk_vpn;
    logic             lk_hit;
    logic [PPN_W-1:0] lk_ppn;
    logic             ins_en;
    logic [VPN_W-1:0] ins_vpn;
    logic [PPN_W-1:0] ins_ppn;
    logic             fault_event;
    logic [VA_W-1:0]  fault_addr;
    logic             tlb_flush;

    assign tlb_flush = flush || ptbase_wr;

    always_ff @(posedge clk) begin
        if (rst)            pt_base <= '0;
        else if (ptbase_wr) pt_base <= ptbase_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_flag  <= 1'b0;
            fault_vaddr <= '0;
        end else if (fault_event) begin
            fault_flag  <= 1'b1;
            fault_vaddr <= fault_addr;
        end else if (fault_clear) begin
            fault_flag  <= 1'b0;
        end
    end

    tlb_cam #(.N(TLB_N)) u_cam (
        .clk     (clk),
        .rst     (rst),
        .lk_vpn  (lk_vpn),
        .lk_hit  (lk_hit),
        .lk_ppn  (lk_ppn),
        .ins_en  (ins_en),
        .ins_vpn (ins_vpn),
        .ins_ppn (ins_ppn),
        .flush   (tlb_flush)
    );

    pt_walker u_walk (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_vaddr    (req_vaddr),
        .rsp_valid    (rsp_valid),
        .rsp_fault    (rsp_fault),
        .rsp_paddr    (rsp_paddr),
        .lk_vpn       (lk_vpn),
        .lk_hit       (lk_hit),
        .lk_ppn       (lk_ppn),
        .ins_en       (ins_en),
        .ins_vpn      (ins_vpn),
        .ins_ppn      (ins_ppn),
        .pt_base      (pt_base),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .fault_event  (fault_event),
        .fault_addr   (fault_addr)
    );

    // R4: an install that is not flushed makes the retry lookup hit
    a_r4_install_hits: assert property (@(posedge clk) disable iff (rst)
        (ins_en && !tlb_flush) |=> lk_hit);

    // R5: a fault response coincides with the sticky flag
    a_r5_fault_flagged: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> fault_flag);

    // R6: the flag only drops through a clear
    a_r6_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        (fault_flag && !fault_clear) |=> fault_flag);

    // R10: a base write leaves the buffer empty
    a_r10_base_flushes: assert property (@(posedge clk) disable iff (rst)
        ptbase_wr |=> !lk_hit);
endmodule

// File: tb/sim_xlat_mmu.sv
`timescale 1ns/1ps
module sim_xlat_mmu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_paddr;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;
    logic        ptbase_wr = 1'b0;
    logic [31:0] ptbase_wdata = '0;
    logic        flush = 1'b0;
    logic        fault_clear = 1'b0;
    logic        fault_flag;
    logic [31:0] fault_vaddr;

    int errors = 0;
    int checks = 0;
    int rd_count = 0;
    logic [31:0] last_rd_addr = '0;
    logic [31:0] cur_base = '0;
    logic [31:0] ptes [64];
    bit inj_flush = 0;
    bit inj_clear = 0;
    bit busy_leak = 0;

    always #10 clk = ~clk;

    xlat_mmu u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .ptbase_wr(ptbase_wr), .ptbase_wdata(ptbase_wdata),
        .flush(flush), .fault_clear(fault_clear),
        .fault_flag(fault_flag), .fault_vaddr(fault_vaddr)
    );

    function automatic logic [31:0] mem_fetch(input logic [31:0] a);
        logic [31:0] off;
        off = (a - cur_base) >> 2;
        if (a[1:0] == 2'b00 && a >= cur_base && off < 64) return ptes[off[5:0]];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_rd_valid <= 1'b0;
            mem_rd_data  <= '0;
        end else begin
            mem_rd_valid <= mem_rd_en;
            if (mem_rd_en) begin
                mem_rd_data  <= mem_fetch(mem_rd_addr);
                last_rd_addr <= mem_rd_addr;
                rd_count     <= rd_count + 1;
            end
        end
    end

    function automatic logic [31:0] mk_pte(input logic [19:0] ppn, input bit ok);
        return {ppn, 11'b0, ok};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic xlat(input logic [31:0] va, output logic [31:0] pa,
                        output bit flt, output int lat);
        bit fl_done = 0;
        bit cl_done = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        busy_leak = 0;
        while (!rsp_valid && lat < 200) begin
            if (req_ready) busy_leak = 1;
            if (mem_rd_valid && inj_flush && !fl_done) begin
                flush = 1'b1; fl_done = 1;
            end else flush = 1'b0;
            if (mem_rd_valid && inj_clear && !cl_done) begin
                fault_clear = 1'b1; cl_done = 1;
            end else fault_clear = 1'b0;
            @(negedge clk);
            lat++;
        end
        flush = 1'b0;
        fault_clear = 1'b0;
        pa  = rsp_paddr;
        flt = rsp_fault;
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        ptbase_wr = 1'b1; ptbase_wdata = b;
        @(negedge clk);
        ptbase_wr = 1'b0;
        cur_base = b;
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R12 req_ready", {31'b0, req_ready}, 32'd1);
        chk(!rsp_valid && !mem_rd_en, "R12 rsp/mem idle",
            {30'b0, rsp_valid, mem_rd_en}, 32'd0);
        chk(!fault_flag && fault_vaddr == 0, "R12 fault state", fault_vaddr, 32'd0);
    endtask

    task automatic t_miss_hit();
        logic [31:0] pa; bit f; int lat; int r0;
        r0 = rd_count;
        xlat(32'h0000_3ABC, pa, f, lat);
        chk(rd_count == r0 + 1, "R3 one read on miss", rd_count, r0 + 1);
        chk(last_rd_addr == 32'h0000_100C, "R3 entry address", last_rd_addr, 32'h100C);
        chk(!f && pa == 32'h0008_3ABC, "R4 walked translation", pa, 32'h0008_3ABC);
        chk(!busy_leak, "R8 ready low during walk", {31'b0, busy_leak}, 0);
        r0 = rd_count;
        xlat(32'h0000_3123, pa, f, lat);
        chk(lat == 1, "R1 hit latency", lat, 1);
        chk(rd_count == r0, "R1 no read on hit", rd_count, r0);
        chk(pa == 32'h0008_3123, "R2 offset passes through", pa, 32'h0008_3123);
    endtask

    task automatic t_fault();
        logic [31:0] pa; bit f; int lat;
        xlat(32'h0001_4678, pa, f, lat);
        chk(f && pa == 0, "R5 fault response", pa, 0);
        chk(fault_flag && fault_vaddr == 32'h0001_4678, "R5 fault address",
            fault_vaddr, 32'h0001_4678);
        repeat (5) @(negedge clk);
        chk(fault_flag, "R6 flag sticky", {31'b0, fault_flag}, 1);
        fault_clear = 1'b1;
        @(negedge clk);
        fault_clear = 1'b0;
        chk(!fault_flag, "R6 flag cleared", {31'b0, fault_flag}, 0);
    endtask

    task automatic t_fault_clear_collide();
        logic [31:0] pa; bit f; int lat;
        xlat(32'h0001_4000, pa, f, lat);
        fault_clear = 1'b1;
        @(negedge clk);
        fault_clear = 1'b0;
        inj_clear = 1;
        xlat(32'h0001_5ABC, pa, f, lat);
        inj_clear = 0;
        chk(f && fault_flag, "R6 set wins over clear", {31'b0, fault_flag}, 1);
        chk(fault_vaddr == 32'h0001_5ABC, "R6 new fault address", fault_vaddr,
            32'h0001_5ABC);
    endtask

    task automatic t_retry_fixed();
        logic [31:0] pa; bit f; int r0; int lat;
        ptes[20] = mk_pte(20'h00099, 1);
        fault_clear = 1'b1;
        @(negedge clk);
        fault_clear = 1'b0;
        r0 = rd_count;
        xlat(32'h0001_4678, pa, f, lat);
        chk(!f && pa == 32'h0009_9678, "R7 retry completes", pa, 32'h0009_9678);
        chk(rd_count == r0 + 1 && !fault_flag, "R7 walked again", rd_count, r0 + 1);
    endtask

    task automatic t_flush_install_collide();
        logic [31:0] pa; bit f; int r0; int lat;
        r0 = rd_count;
        inj_flush = 1;
        xlat(32'h0000_5010, pa, f, lat);
        inj_flush = 0;
        chk(rd_count == r0 + 2, "R9 install discarded by flush", rd_count, r0 + 2);
        chk(!f && pa == 32'h0008_5010, "R9 translation after rewalk", pa, 32'h0008_5010);
        r0 = rd_count;
        xlat(32'h0000_5FFF, pa, f, lat);
        chk(lat == 1 && rd_count == r0, "R4 later hit", rd_count, r0);
    endtask

    task automatic t_flush();
        logic [31:0] pa; bit f; int r0; int lat;
        pulse_flush();
        r0 = rd_count;
        xlat(32'h0000_3000, pa, f, lat);
        chk(rd_count == r0 + 1 && pa == 32'h0008_3000, "R9 flush empties", rd_count,
            r0 + 1);
    endtask

    task automatic t_base_write();
        logic [31:0] pa; bit f; int r0; int lat;
        set_base(32'h0000_2000);
        r0 = rd_count;
        xlat(32'h0000_5444, pa, f, lat);
        chk(rd_count == r0 + 1, "R10 base write flushed", rd_count, r0 + 1);
        chk(last_rd_addr == 32'h0000_2014, "R10 new base used", last_rd_addr,
            32'h0000_2014);
        chk(pa == 32'h0008_5444, "R10 translation", pa, 32'h0008_5444);
    endtask

    task automatic t_round_robin();
        logic [31:0] pa; bit f; int r0; int lat;
        pulse_flush();
        for (int v = 0; v < 9; v++) xlat({v[19:0], 12'h010}, pa, f, lat);
        r0 = rd_count;
        xlat(32'h0000_2020, pa, f, lat);
        chk(rd_count == r0 && pa == 32'h0008_2020, "R11 third page kept", rd_count, r0);
        r0 = rd_count;
        xlat(32'h0000_0030, pa, f, lat);
        chk(rd_count == r0 + 1 && pa == 32'h0008_0030, "R11 first page evicted",
            rd_count, r0 + 1);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) ptes[i] = mk_pte(20'(i + 'h80), 1);
        ptes[20] = 32'h0;
        ptes[21] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        set_base(32'h0000_1000);
        t_miss_hit();
        t_fault();
        t_fault_clear_collide();
        t_retry_fixed();
        t_flush_install_collide();
        t_flush();
        t_base_write();
        t_round_robin();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R12 watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule